// File: doc/BRIEF.md
# Dual 32-bit Add/Subtract Accumulate Unit

This execution unit belongs to a small SIMD extension and owns that extension's fifteen 32-bit registers. Register index 0 reads as zero and cannot be written. The unit takes a 32-bit instruction word with a valid strobe. When the major opcode in the low six bits selects its group, it decodes one of three dual-lane forms. Each form adds or subtracts combinations of two source registers (B and C) into up to two destination registers (A and D). The pattern bits choose addition or subtraction separately for each lane. Both destination updates complete on the clock edge that captures the instruction.

A side port loads and reads registers, since load/store is handled elsewhere. The read half is combinational. The write half is accepted only when no instruction is being presented. The fourth sub-opcode of the group is reserved: it causes a one-cycle exception pulse and changes no register.

A three-state machine records what the previous edge did. ST_IDLE means no group instruction was taken. ST_EXEC means a valid form was executed. ST_TRAP means a reserved form was seen. On every edge the machine moves to ST_EXEC or ST_TRAP when a group instruction is valid, and otherwise returns to ST_IDLE. The exception output is high exactly while the machine is in ST_TRAP.

Top module: `dacc_unit`

## Requirements
- R1: An instruction is taken only when insn_valid is high and insn_word[5:0] equals 6'h19. Any other word changes no register and raises no exception.
- R2: Sub-opcode insn_word[23:22] = 3 changes no register. It drives rsv_exc high for the one cycle after the capturing edge.
- R3: Sub-opcode 0 (accumulate form) performs A += (pat[1] ? B-C : B+C) and D += (pat[0] ? B-C : B+C). The fields are pat = insn_word[25:24], D index = [21:18], C index = [17:14], B index = [13:10] and A index = [9:6].
- R4: Sub-opcode 1 (mixed form) adds B+C to A when pat[1] is 0 and subtracts it when pat[1] is 1. It adds B-C to D when pat[0] is 0 and subtracts it when pat[0] is 1.
- R5: Sub-opcode 2 (sum form) adds B to A or subtracts it, chosen by pat[1]. It adds C to D or subtracts it, chosen by pat[0].
- R6: Index 0 reads as zero. A destination index of 0 suppresses that lane's write, and when both destination indices are 0 nothing changes.
- R7: Both sources are read before either destination is written, so a destination that aliases a source does not disturb the other lane.
- R8: When A and D name the same nonzero register, the D contribution is applied on top of the updated A value.
- R9: All arithmetic is 32-bit two's complement and wraps modulo 2^32.
- R10: A synchronous active-high reset clears every register and the exception output.
- R11: dbg_wr_en writes dbg_wr_data to register dbg_sel, but only while insn_valid is low. Index 0 is ignored. dbg_rd_data always shows register dbg_sel, and index 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Instruction word |
| rsv_exc | output | 1 | Reserved-instruction exception pulse |
| dbg_sel | input | 4 | Register index for debug read/load |
| dbg_wr_en | input | 1 | Debug load enable |
| dbg_wr_data | input | 32 | Debug load value |
| dbg_rd_data | output | 32 | Contents of register dbg_sel |

## Verification
The hardest case to reach is the one where aliasing and chaining combine. Here A equals D, and one of them also equals B or C, so the second update must use the first update's result while both source operands still hold their old values. Random registers are seeded through the load port. Directed words then alias every field combination, and a long random run draws indices from a small range so that collisions stay frequent. A model in the bench is checked against every register after each burst, and each instruction's exception outcome is checked through a scoreboard queue.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int IDX_W = 4;
    localparam int MAJ_W = 6;
    localparam logic [MAJ_W-1:0] MAJ_GROUP = 6'h19;

    typedef enum logic [1:0] {
        FORM_ACC  = 2'd0,
        FORM_ACCM = 2'd1,
        FORM_ASUM = 2'd2,
        FORM_RSVD = 2'd3
    } form_e;

    // Instruction layout, bits [25:0]
    typedef struct packed {
        logic [1:0]       pat;
        form_e            form;
        logic [IDX_W-1:0] idx_d;
        logic [IDX_W-1:0] idx_c;
        logic [IDX_W-1:0] idx_b;
        logic [IDX_W-1:0] idx_a;
        logic [MAJ_W-1:0] major;
    } insn_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_TRAP = 2'd2
    } state_e;

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
    import dacc_pkg::*;
(
    input  logic              insn_valid,
    input  logic [25:0]       insn_low,
    output form_e             form,
    output logic [1:0]        pat,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b,
    output logic [IDX_W-1:0]  idx_c,
    output logic [IDX_W-1:0]  idx_d,
    output logic              grp_hit,
    output logic              rsvd_hit,
    output logic              wr_a_en,
    output logic              wr_d_en
);
    insn_t fields;
    logic  exec_hit;

    assign fields = insn_t'(insn_low);

    always_comb begin
        form     = fields.form;
        pat      = fields.pat;
        idx_a    = fields.idx_a;
        idx_b    = fields.idx_b;
        idx_c    = fields.idx_c;
        idx_d    = fields.idx_d;
        grp_hit  = insn_valid && (fields.major == MAJ_GROUP);
        rsvd_hit = grp_hit && (fields.form == FORM_RSVD);
        exec_hit = grp_hit && (fields.form != FORM_RSVD);
        wr_a_en  = exec_hit && (fields.idx_a != '0);
        wr_d_en  = exec_hit && (fields.idx_d != '0);
    end
endmodule

// File: rtl/dacc_lane.sv
module dacc_lane
    import dacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE   = 0     // 0: lane A, 1: lane D
)(
    input  form_e              form,
    input  logic               neg,
    input  logic [DATA_W-1:0]  opb,
    input  logic [DATA_W-1:0]  opc,
    output logic [DATA_W-1:0]  delta
);
    logic [DATA_W-1:0] sum_bc;
    logic [DATA_W-1:0] dif_bc;
    logic [DATA_W-1:0] mixed_base;
    logic [DATA_W-1:0] single_base;

    assign sum_bc = opb + opc;
    assign dif_bc = opb - opc;

    generate
        if (LANE == 0) begin : g_lane_a
            assign mixed_base  = sum_bc;
            assign single_base = opb;
        end else begin : g_lane_d
            assign mixed_base  = dif_bc;
            assign single_base = opc;
        end
    endgenerate

    always_comb begin
        unique case (form)
            FORM_ACC:  delta = neg ? dif_bc : sum_bc;
            FORM_ACCM: delta = neg ? (DATA_W'(0) - mixed_base) : mixed_base;
            FORM_ASUM: delta = neg ? (DATA_W'(0) - single_base) : single_base;
            default:   delta = '0;
        endcase
    end
endmodule

// File: rtl/dacc_regfile.sv
module dacc_regfile
    import dacc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 15
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [IDX_W-1:0]  c_idx,
    output logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] c_val,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  d_idx,
    input  logic              wr_a_en,
    input  logic              wr_d_en,
    input  logic [DATA_W-1:0] delta_a,
    input  logic [DATA_W-1:0] delta_d,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_val
);
    logic [DATA_W-1:0] ent_q [REG_CNT];
    logic [DATA_W-1:0] old_a;
    logic [DATA_W-1:0] old_d;
    logic [DATA_W-1:0] new_a;
    logic [DATA_W-1:0] base_d;
    logic [DATA_W-1:0] new_d;

    // Five read ports; unmatched index (0 or beyond REG_CNT) reads zero
    always_comb begin
        b_val    = '0;
        c_val    = '0;
        old_a    = '0;
        old_d    = '0;
        peek_val = '0;
        for (int i = 0; i < REG_CNT; i++) begin
            if (b_idx    == IDX_W'(i + 1)) b_val    = ent_q[i];
            if (c_idx    == IDX_W'(i + 1)) c_val    = ent_q[i];
            if (a_idx    == IDX_W'(i + 1)) old_a    = ent_q[i];
            if (d_idx    == IDX_W'(i + 1)) old_d    = ent_q[i];
            if (peek_idx == IDX_W'(i + 1)) peek_val = ent_q[i];
        end
    end

    // Lane D chains onto lane A's result when both name one register
    always_comb begin
        new_a  = old_a + delta_a;
        base_d = (wr_a_en && (a_idx == d_idx)) ? new_a : old_d;
        new_d  = base_d + delta_d;
    end

    generate
        for (genvar e = 0; e < REG_CNT; e++) begin : g_ent
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e + 1);
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_d_en && (d_idx == MY_IDX)) begin
                    q <= new_d;
                end else if (wr_a_en && (a_idx == MY_IDX)) begin
                    q <= new_a;
                end else if (ld_en && (ld_idx == MY_IDX)) begin
                    q <= ld_data;
                end
            end
            assign ent_q[e] = q;
        end
    endgenerate
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 15
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    output logic              rsv_exc,
    input  logic [3:0]        dbg_sel,
    input  logic              dbg_wr_en,
    input  logic [DATA_W-1:0] dbg_wr_data,
    output logic [DATA_W-1:0] dbg_rd_data
);
    localparam int LANES = 2;

    form_e             form;
    logic [1:0]        pat;
    logic [IDX_W-1:0]  idx_a;
    logic [IDX_W-1:0]  idx_b;
    logic [IDX_W-1:0]  idx_c;
    logic [IDX_W-1:0]  idx_d;
    logic              grp_hit;
    logic              rsvd_hit;
    logic              wr_a_en;
    logic              wr_d_en;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] opc;
    logic [DATA_W-1:0] lane_delta [LANES];
    logic              ld_go;
    state_e            state_q;
    state_e            state_n;

    dacc_decode u_dec (
        .insn_valid (insn_valid),
        .insn_low   (insn_word[25:0]),
        .form       (form),
        .pat        (pat),
        .idx_a      (idx_a),
        .idx_b      (idx_b),
        .idx_c      (idx_c),
        .idx_d      (idx_d),
        .grp_hit    (grp_hit),
        .rsvd_hit   (rsvd_hit),
        .wr_a_en    (wr_a_en),
        .wr_d_en    (wr_d_en)
    );

    // Lane 0 (A) is steered by pat[1], lane 1 (D) by pat[0]
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            dacc_lane #(.DATA_W(DATA_W), .LANE(l)) u_lane (
                .form  (form),
                .neg   (pat[LANES-1-l]),
                .opb   (opb),
                .opc   (opc),
                .delta (lane_delta[l])
            );
        end
    endgenerate

    assign ld_go = dbg_wr_en && !insn_valid;

    dacc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .b_idx    (idx_b),
        .c_idx    (idx_c),
        .b_val    (opb),
        .c_val    (opc),
        .a_idx    (idx_a),
        .d_idx    (idx_d),
        .wr_a_en  (wr_a_en),
        .wr_d_en  (wr_d_en),
        .delta_a  (lane_delta[0]),
        .delta_d  (lane_delta[1]),
        .ld_en    (ld_go),
        .ld_idx   (dbg_sel),
        .ld_data  (dbg_wr_data),
        .peek_idx (dbg_sel),
        .peek_val (dbg_rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_EXEC, ST_TRAP: begin
                if (rsvd_hit)     state_n = ST_TRAP;
                else if (grp_hit) state_n = ST_EXEC;
                else              state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_TRAP: rsv_exc = 1'b1;
            default: rsv_exc = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacc_checks.sv
module dacc_checks (
    input logic        clk,
    input logic        rst,
    input logic        insn_valid,
    input logic [31:0] insn_word,
    input logic        rsv_exc,
    input logic        wr_a_en,
    input logic        wr_d_en
);
    logic is_grp;
    logic is_rsvd;
    assign is_grp  = insn_valid && (insn_word[5:0] == 6'h19);
    assign is_rsvd = is_grp && (insn_word[23:22] == 2'b11);

    assert_word_known_R1: assert property (@(posedge clk) disable iff (rst)
        insn_valid |-> !$isunknown(insn_word));

    assert_foreign_nowrite_R1: assert property (@(posedge clk) disable iff (rst)
        !is_grp |-> (!wr_a_en && !wr_d_en));

    assert_trap_follows_R2: assert property (@(posedge clk) disable iff (rst)
        is_rsvd |=> rsv_exc);

    assert_trap_cause_R2: assert property (@(posedge clk) disable iff (rst)
        rsv_exc |-> $past(is_rsvd));

    assert_rsvd_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
        is_rsvd |-> (!wr_a_en && !wr_d_en));

    assert_zero_dest_a_R6: assert property (@(posedge clk) disable iff (rst)
        wr_a_en |-> (insn_word[9:6] != 4'd0));

    assert_zero_dest_d_R6: assert property (@(posedge clk) disable iff (rst)
        wr_d_en |-> (insn_word[21:18] != 4'd0));
endmodule

bind dacc_unit dacc_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .rsv_exc    (rsv_exc),
    .wr_a_en    (wr_a_en),
    .wr_d_en    (wr_d_en)
);

// File: tb/test_dacc_unit.sv
module test_dacc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        insn_valid;
    logic [31:0] insn_word;
    logic        rsv_exc;
    logic [3:0]  dbg_sel;
    logic        dbg_wr_en;
    logic [31:0] dbg_wr_data;
    logic [31:0] dbg_rd_data;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model [16];
    bit          exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    dacc_unit i_dacc_unit (
        .clk         (clk),
        .rst         (rst),
        .insn_valid  (insn_valid),
        .insn_word   (insn_word),
        .rsv_exc     (rsv_exc),
        .dbg_sel     (dbg_sel),
        .dbg_wr_en   (dbg_wr_en),
        .dbg_wr_data (dbg_wr_data),
        .dbg_rd_data (dbg_rd_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int pat, int sub, int d, int c, int b, int a, int maj = 'h19);
        return {6'd0, 2'(pat), 2'(sub), 4'(d), 4'(c), 4'(b), 4'(a), 6'(maj)};
    endfunction

    // Reference model, written from R1..R9
    function automatic bit ref_apply(logic [31:0] w);
        logic [31:0] vb, vc, da, dd;
        logic [1:0]  p;
        if (w[5:0] != 6'h19) return 1'b0;
        if (w[23:22] == 2'd3) return 1'b1;
        p  = w[25:24];
        vb = model[w[13:10]];
        vc = model[w[17:14]];
        case (w[23:22])
            2'd0: begin
                da = p[1] ? vb - vc : vb + vc;
                dd = p[0] ? vb - vc : vb + vc;
            end
            2'd1: begin
                da = p[1] ? -(vb + vc) : vb + vc;
                dd = p[0] ? -(vb - vc) : vb - vc;
            end
            default: begin
                da = p[1] ? -vb : vb;
                dd = p[0] ? -vc : vc;
            end
        endcase
        if (w[9:6] != 0)   model[w[9:6]]   = model[w[9:6]] + da;
        if (w[21:18] != 0) model[w[21:18]] = model[w[21:18]] + dd;
        return 1'b0;
    endfunction

    // Monitor: exception outcome of each issued word
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            chk("R2 exception pulse", {31'd0, rsv_exc}, {31'd0, e});
        end else if (!rst && rsv_exc) begin
            chk("R2 spurious exception", {31'd0, rsv_exc}, 32'd0);
        end
    end

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        dbg_wr_en  = 1'b0;
        insn_valid = 1'b1;
        insn_word  = w;
        exp_q.push_back(ref_apply(w));
    endtask

    task automatic load(int idx, logic [31:0] v);
        @(negedge clk);
        insn_valid  = 1'b0;
        dbg_wr_en   = 1'b1;
        dbg_sel     = 4'(idx);
        dbg_wr_data = v;
        if (idx != 0) model[idx] = v;
    endtask

    task automatic idle();
        @(negedge clk);
        insn_valid = 1'b0;
        dbg_wr_en  = 1'b0;
    endtask

    task automatic check_regs(string tag);
        idle();
        for (int i = 0; i < 16; i++) begin
            dbg_sel = 4'(i);
            #1;
            chk(tag, dbg_rd_data, model[i]);
        end
    endtask

    task automatic peek(int idx, logic [31:0] exp, string tag);
        idle();
        dbg_sel = 4'(idx);
        #1;
        chk(tag, dbg_rd_data, exp);
    endtask

    task automatic seed(int lo);
        for (int i = 1; i < 16; i++) load(i, $urandom() + 32'(lo));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst = 1'b1; insn_valid = 1'b0; insn_word = '0;
        dbg_sel = '0; dbg_wr_en = 1'b0; dbg_wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_regs("R10 reset clears registers");

        // R11 load port, index 0 ignored, load blocked under valid
        load(3, 32'd100); load(1, 32'd5); load(2, 32'd3); load(0, 32'hDEAD_BEEF);
        peek(0, 32'd0, "R11 index 0 not writable");
        peek(3, 32'd100, "R11 load value");
        @(negedge clk);
        insn_valid = 1'b1; insn_word = mk(0, 0, 0, 0, 0, 0, 'h05);
        dbg_wr_en = 1'b1; dbg_sel = 4'd3; dbg_wr_data = 32'h1234_5678;
        exp_q.push_back(1'b0);
        peek(3, 32'd100, "R11 load blocked while valid");

        // R3 literal: r3 += r1+r2 ; r4 += r1+r2
        issue(mk(0, 0, 4, 2, 1, 3));
        peek(3, 32'd108, "R3 accumulate lane A");
        peek(4, 32'd8, "R3 accumulate lane D");
        for (int p = 0; p < 4; p++) issue(mk(p, 0, 6, 2, 1, 5));
        check_regs("R3 accumulate patterns");

        // R4 mixed form, every pattern
        for (int p = 0; p < 4; p++) issue(mk(p, 1, 8, 3, 1, 7));
        check_regs("R4 mixed patterns");

        // R5 sum form, every pattern
        for (int p = 0; p < 4; p++) issue(mk(p, 2, 10, 2, 3, 9));
        check_regs("R5 sum patterns");

        // R9 wrap: r11 = FFFFFFFF, add r12=1 via sum form
        load(11, 32'hFFFF_FFFF); load(12, 32'd1);
        issue(mk(0, 2, 0, 12, 12, 11));
        peek(11, 32'd0, "R9 wraps to zero");
        issue(mk(2, 2, 0, 12, 12, 11));
        peek(11, 32'hFFFF_FFFF, "R9 wraps below zero");

        // R2 reserved: no register change
        seed(0);
        issue(mk(1, 3, 4, 2, 1, 3));
        issue(mk(0, 3, 5, 5, 5, 5));
        check_regs("R2 reserved form leaves registers");

        // R1 foreign major opcodes
        issue(mk(0, 0, 4, 2, 1, 3, 'h18));
        issue(mk(0, 0, 4, 2, 1, 3, 'h39));
        check_regs("R1 foreign opcode ignored");

        // R6 zero destinations and zero sources
        issue(mk(0, 0, 0, 2, 1, 0));
        issue(mk(3, 1, 0, 0, 0, 7));
        issue(mk(3, 2, 9, 0, 4, 0));
        check_regs("R6 zero index handling");

        // R7 destination aliases a source
        issue(mk(0, 0, 2, 2, 1, 1));
        issue(mk(1, 1, 3, 4, 3, 4));
        issue(mk(2, 2, 5, 6, 5, 6));
        check_regs("R7 sources read before writes");

        // R8 A and D name one register, also aliasing sources
        issue(mk(0, 0, 7, 2, 1, 7));
        issue(mk(3, 1, 8, 8, 8, 8));
        issue(mk(1, 2, 9, 9, 3, 9));
        check_regs("R8 chained same-register update");

        // Mixed random run, small index range to force collisions
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r == 0)      load(int'($urandom_range(0, 15)), $urandom());
            else if (r == 1) issue(mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                                      1, 2, 3, 4, int'($urandom_range(0, 63))));
            else             issue(mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                                      int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                                      int'($urandom_range(0, 5)), int'($urandom_range(0, 5))));
            if ((k % 50) == 49) check_regs("R3 R4 R5 R8 random run");
        end
        check_regs("R7 R9 random run final");

        idle();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule